// File: doc/BRIEF.md
# Microcontroller Boot and Run Controller

This block starts firmware that has already been loaded into an embedded engine. It then collects the value the firmware leaves behind. A start request first checks the engine's configuration word. The revision field and the security-model field must hold legal encodings. When the caller asks for dual-core operation, the word must also report a RISC-V capable core. If any of these checks fails, the sequence stops with an error code, and no engine register is touched.

When the checks pass, the block writes either mailbox register, each only if its enable was set with the request. It then issues one CPU start command. The command goes through the alias control path when the engine's alias-enable bit is set, and through the normal control path otherwise. The block then waits for the engine to report that it has halted. On halt it captures both mailbox registers as two 32-bit results. If the halt does not come within a bounded number of cycles, it reports a timeout instead. By default that bound is two seconds at 125 MHz.

Each sequence ends with a one-cycle done pulse. The results, the error code and the reported subversion then stay unchanged until the next start is accepted.

Top module: `mcu_boot_run`

## Requirements
- R1: After reset, busy, done, errCode, subVer, res0, res1 and every write and start strobe are zero.
- R2: The revision field is cfgWord[3:0]. Only 1 to 7 is legal. Any other value ends the run with errCode 1 and done two cycles after the cycle in which startReq is sampled. In that case no mailbox write and no start pulse occurs.
- R3: The security-model field is cfgWord[10:8]. Only 0, 2 and 3 are legal. Any other value ends the run like R2 but with errCode 2. A bad revision takes precedence over a bad security model.
- R4: subVer reports the low two bits of the subversion field cfgWord[7:4], sampled during the check. All four values are accepted.
- R5: With needDual high and the capability bit cfgWord[12] low, and no earlier field error, the run ends like R2 with errCode 3.
- R6: mbxWrEn[0] and mbxWrEn[1] are sampled with startReq. Each enabled mailbox gets exactly one write pulse carrying the data sampled with startReq. The pulses come before the start pulse. A disabled mailbox gets no write.
- R7: Exactly one start pulse is issued per valid run. It goes on startAlias when aliasEn was high in the cycle before the pulse, and on startNormal otherwise.
- R8: When engHalted is seen while waiting, res0 and res1 take engMbx0 and engMbx1, errCode is 0, and done pulses for one cycle. A halt seen in the final waiting cycle still counts as success.
- R9: If TIMEOUT_CYCLES waiting cycles pass with no halt, errCode becomes 4 and res0 and res1 stay 0. done arrives TIMEOUT_CYCLES+4 cycles after startReq is sampled.
- R10: startReq is ignored while busy. res0, res1, errCode and subVer hold their values from done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request to validate and run, taken when idle |
| needDual | input | 1 | Caller requires a RISC-V capable core |
| cfgWord | input | 32 | Engine configuration word |
| aliasEn | input | 1 | Alias-enable bit of the engine CPU control register |
| mbxWrEn | input | 2 | Per-mailbox write enable (bit 0: mailbox 0) |
| mbx0In | input | 32 | Value to write to mailbox 0 |
| mbx1In | input | 32 | Value to write to mailbox 1 |
| engMbx0 | input | 32 | Current content of engine mailbox 0 |
| engMbx1 | input | 32 | Current content of engine mailbox 1 |
| engHalted | input | 1 | Engine halted status |
| mbx0Wr | output | 1 | Write strobe for mailbox 0 |
| mbx0WrData | output | 32 | Data for mailbox 0 |
| mbx1Wr | output | 1 | Write strobe for mailbox 1 |
| mbx1WrData | output | 32 | Data for mailbox 1 |
| startNormal | output | 1 | Start pulse through the normal control register |
| startAlias | output | 1 | Start pulse through the alias control register |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| errCode | output | 3 | 0 ok, 1 revision, 2 security, 3 dual-core, 4 timeout |
| subVer | output | 2 | Reported revision subversion |
| res0 | output | 32 | Captured mailbox 0 result |
| res1 | output | 32 | Captured mailbox 1 result |

## Verification
The assertions assume that the engine raises its halted status only after a start pulse. They also assume that aliasEn and cfgWord do not change while a sequence is in flight, so the chosen start path and the checked fields belong to the same request. The stimulus clears the halted status and sets every input before it raises startReq, and it holds them until done. The only exception is a deliberate second startReq pulse issued during the wait phase. Halt delays are drawn both inside and just beyond the timeout window, so both outcomes meet the bounded-duration check.

// File: rtl/mcu_boot_pkg.sv
package mcu_boot_pkg;

  localparam int REV_LSB   = 0;
  localparam int REV_W     = 4;
  localparam int SUB_LSB   = 4;
  localparam int SEC_LSB   = 8;
  localparam int SEC_W     = 3;
  localparam int RISCV_BIT = 12;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_REV     = 3'd1,
    ERR_SEC     = 3'd2,
    ERR_DUAL    = 3'd3,
    ERR_TIMEOUT = 3'd4
  } bootErr_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_MBOX, ST_LAUNCH, ST_WAIT
  } bootSt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     accept;
    logic     checkPhase;
    logic     setErr;
    bootErr_e errVal;
    logic     mbxPhase;
    logic     launch;
    logic     timerRun;
    logic     capture;
  } bootStb_t;

endpackage

// File: rtl/mcu_boot_dp.sv
module mcu_boot_dp
  import mcu_boot_pkg::*;
#(
  parameter int CFG_W          = 32,
  parameter int MBX_W          = 32,
  parameter int TIMEOUT_CYCLES = 250_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  bootStb_t         stb,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             needDual,
  input  logic             aliasEn,
  input  logic [1:0]       mbxWrEn,
  input  logic [MBX_W-1:0] mbx0In,
  input  logic [MBX_W-1:0] mbx1In,
  input  logic [MBX_W-1:0] engMbx0,
  input  logic [MBX_W-1:0] engMbx1,
  output bootErr_e         cfgErr,
  output logic             timeoutHit,
  output logic             mbx0Wr,
  output logic [MBX_W-1:0] mbx0WrData,
  output logic             mbx1Wr,
  output logic [MBX_W-1:0] mbx1WrData,
  output logic             startNormal,
  output logic             startAlias,
  output logic [MBX_W-1:0] res0,
  output logic [MBX_W-1:0] res1,
  output bootErr_e         errQ,
  output logic [1:0]       subVer
);

  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TW-1:0] LAST_TICK = TW'(TIMEOUT_CYCLES - 1);

  logic [REV_W-1:0] revField;
  logic [SEC_W-1:0] secField;
  logic             revOk, secOk, dualOk;

  logic [1:0]       mbxEnQ;
  logic [MBX_W-1:0] mbx0Q, mbx1Q;
  logic             selAliasQ;
  logic [TW-1:0]    timer;

  // field validation, priority revision > security > dual-core
  always_comb begin
    revField = cfgWord[REV_LSB +: REV_W];
    secField = cfgWord[SEC_LSB +: SEC_W];
    revOk    = (revField >= REV_W'(1)) && (revField <= REV_W'(7));
    secOk    = (secField == SEC_W'(0)) || (secField == SEC_W'(2)) ||
               (secField == SEC_W'(3));
    dualOk   = !needDual || cfgWord[RISCV_BIT];
    if (!revOk)       cfgErr = ERR_REV;
    else if (!secOk)  cfgErr = ERR_SEC;
    else if (!dualOk) cfgErr = ERR_DUAL;
    else              cfgErr = ERR_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mbxEnQ    <= '0;
      mbx0Q     <= '0;
      mbx1Q     <= '0;
      res0      <= '0;
      res1      <= '0;
      errQ      <= ERR_NONE;
      subVer    <= '0;
      selAliasQ <= 1'b0;
    end else begin
      if (stb.accept) begin
        mbxEnQ <= mbxWrEn;
        mbx0Q  <= mbx0In;
        mbx1Q  <= mbx1In;
        res0   <= '0;
        res1   <= '0;
        errQ   <= ERR_NONE;
      end
      if (stb.checkPhase) subVer    <= cfgWord[SUB_LSB +: 2];
      if (stb.setErr)     errQ      <= stb.errVal;
      if (stb.mbxPhase)   selAliasQ <= aliasEn;
      if (stb.capture) begin
        res0 <= engMbx0;
        res1 <= engMbx1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              timer <= '0;
    else if (!stb.timerRun) timer <= '0;
    else                    timer <= timer + 1'b1;
  end

  assign timeoutHit  = (timer == LAST_TICK);
  assign mbx0Wr      = stb.mbxPhase & mbxEnQ[0];
  assign mbx1Wr      = stb.mbxPhase & mbxEnQ[1];
  assign mbx0WrData  = mbx0Q;
  assign mbx1WrData  = mbx1Q;
  assign startAlias  = stb.launch & selAliasQ;
  assign startNormal = stb.launch & ~selAliasQ;

endmodule

// File: rtl/mcu_boot_ctrl.sv
module mcu_boot_ctrl
  import mcu_boot_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  bootErr_e cfgErr,
  input  logic     timeoutHit,
  input  logic     engHalted,
  output bootStb_t stb,
  output logic     done,
  output logic     busy
);

  bootSt_e state, nxtState;
  logic    finish;

  always_comb begin
    stb      = '0;
    nxtState = state;
    finish   = 1'b0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        stb.accept = 1'b1;
        nxtState   = ST_CHECK;
      end
      ST_CHECK: begin
        stb.checkPhase = 1'b1;
        if (cfgErr != ERR_NONE) begin
          stb.setErr = 1'b1;
          stb.errVal = cfgErr;
          finish     = 1'b1;
          nxtState   = ST_IDLE;
        end else begin
          nxtState = ST_MBOX;
        end
      end
      ST_MBOX: begin
        stb.mbxPhase = 1'b1;
        nxtState     = ST_LAUNCH;
      end
      ST_LAUNCH: begin
        stb.launch = 1'b1;
        nxtState   = ST_WAIT;
      end
      ST_WAIT: begin
        stb.timerRun = 1'b1;
        if (engHalted) begin
          stb.capture = 1'b1;
          finish      = 1'b1;
          nxtState    = ST_IDLE;
        end else if (timeoutHit) begin
          stb.setErr = 1'b1;
          stb.errVal = ERR_TIMEOUT;
          finish     = 1'b1;
          nxtState   = ST_IDLE;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxtState;
      done  <= finish;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/mcu_boot_run.sv
module mcu_boot_run
  import mcu_boot_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 250_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        needDual,
  input  logic [31:0] cfgWord,
  input  logic        aliasEn,
  input  logic [1:0]  mbxWrEn,
  input  logic [31:0] mbx0In,
  input  logic [31:0] mbx1In,
  input  logic [31:0] engMbx0,
  input  logic [31:0] engMbx1,
  input  logic        engHalted,
  output logic        mbx0Wr,
  output logic [31:0] mbx0WrData,
  output logic        mbx1Wr,
  output logic [31:0] mbx1WrData,
  output logic        startNormal,
  output logic        startAlias,
  output logic        busy,
  output logic        done,
  output logic [2:0]  errCode,
  output logic [1:0]  subVer,
  output logic [31:0] res0,
  output logic [31:0] res1
);

  bootStb_t stb;
  bootErr_e cfgErr;
  bootErr_e errQ;
  logic     timeoutHit;

  mcu_boot_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .cfgErr    (cfgErr),
    .timeoutHit(timeoutHit),
    .engHalted (engHalted),
    .stb       (stb),
    .done      (done),
    .busy      (busy)
  );

  mcu_boot_dp #(
    .CFG_W         (32),
    .MBX_W         (32),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cfgWord    (cfgWord),
    .needDual   (needDual),
    .aliasEn    (aliasEn),
    .mbxWrEn    (mbxWrEn),
    .mbx0In     (mbx0In),
    .mbx1In     (mbx1In),
    .engMbx0    (engMbx0),
    .engMbx1    (engMbx1),
    .cfgErr     (cfgErr),
    .timeoutHit (timeoutHit),
    .mbx0Wr     (mbx0Wr),
    .mbx0WrData (mbx0WrData),
    .mbx1Wr     (mbx1Wr),
    .mbx1WrData (mbx1WrData),
    .startNormal(startNormal),
    .startAlias (startAlias),
    .res0       (res0),
    .res1       (res1),
    .errQ       (errQ),
    .subVer     (subVer)
  );

  assign errCode = errQ;

endmodule

// File: rtl/mcu_boot_chk.sv
module mcu_boot_chk #(
  parameter int TIMEOUT_CYCLES = 250_000_000
) (
  input logic        clk,
  input logic        rstN,
  input logic        startReq,
  input logic        aliasEn,
  input logic        mbx0Wr,
  input logic        mbx1Wr,
  input logic        startNormal,
  input logic        startAlias,
  input logic        busy,
  input logic        done,
  input logic [2:0]  errCode,
  input logic [31:0] res0,
  input logic [31:0] res1
);

  localparam int CW = $clog2(TIMEOUT_CYCLES + 8);
  localparam logic [CW-1:0] BUSY_MAX = CW'(TIMEOUT_CYCLES + 4);

  logic [CW-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  AST_ONE_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startNormal, startAlias}));                                 // R7
  AST_ALIAS_SRC: assert property (@(posedge clk) disable iff (!rstN)
    startAlias |-> $past(aliasEn));                                       // R7
  AST_NORMAL_SRC: assert property (@(posedge clk) disable iff (!rstN)
    startNormal |-> !$past(aliasEn));                                     // R7
  AST_MBX_IN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (mbx0Wr || mbx1Wr) |-> busy);                                         // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                                      // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startReq) |=> ($stable(res0) && $stable(res1) && $stable(errCode))); // R10
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= BUSY_MAX);                                                 // R9

endmodule

bind mcu_boot_run mcu_boot_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startReq   (startReq),
  .aliasEn    (aliasEn),
  .mbx0Wr     (mbx0Wr),
  .mbx1Wr     (mbx1Wr),
  .startNormal(startNormal),
  .startAlias (startAlias),
  .busy       (busy),
  .done       (done),
  .errCode    (errCode),
  .res0       (res0),
  .res1       (res1)
);

// File: tb/tb_mcu_boot_run.sv
module tb_mcu_boot_run;

  localparam int T = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        needDual = 1'b0;
  logic [31:0] cfgWord = 32'h0000_0001;
  logic        aliasEn = 1'b0;
  logic [1:0]  mbxWrEn = 2'b00;
  logic [31:0] mbx0In = '0, mbx1In = '0;
  logic [31:0] mb0 = '0, mb1 = '0;
  logic        halted = 1'b0;
  logic        mbx0Wr, mbx1Wr, startNormal, startAlias, busy, done;
  logic [31:0] mbx0WrData, mbx1WrData, res0, res1;
  logic [2:0]  errCode;
  logic [1:0]  subVer;

  int checks = 0, errors = 0;
  bit finished = 0;
  int wr0Cnt, wr1Cnt, normCnt, aliasCnt, cnt, haltDelay;
  bit launchSeen, orderBad, running;
  logic [31:0] wr0Data, wr1Data;

  always #4 clk = ~clk;

  mcu_boot_run #(.TIMEOUT_CYCLES(T)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .needDual(needDual),
    .cfgWord(cfgWord), .aliasEn(aliasEn), .mbxWrEn(mbxWrEn),
    .mbx0In(mbx0In), .mbx1In(mbx1In), .engMbx0(mb0), .engMbx1(mb1),
    .engHalted(halted), .mbx0Wr(mbx0Wr), .mbx0WrData(mbx0WrData),
    .mbx1Wr(mbx1Wr), .mbx1WrData(mbx1WrData), .startNormal(startNormal),
    .startAlias(startAlias), .busy(busy), .done(done), .errCode(errCode),
    .subVer(subVer), .res0(res0), .res1(res1)
  );

  function automatic logic [31:0] fw0(input logic [31:0] x);
    return x ^ 32'h5A5A_F00F;
  endfunction
  function automatic logic [31:0] fw1(input logic [31:0] x);
    return x + 32'h0000_1234;
  endfunction

  function automatic logic [2:0] expErr(input logic [31:0] c, input logic d);
    logic [3:0] r;
    logic [2:0] s;
    r = c[3:0];
    s = c[10:8];
    if (r == 4'd0 || r > 4'd7) return 3'd1;
    if (!(s == 3'd0 || s == 3'd2 || s == 3'd3)) return 3'd2;
    if (d && !c[12]) return 3'd3;
    return 3'd0;
  endfunction

  // engine model: mailboxes, start decode, firmware halting after haltDelay
  always @(negedge clk) begin
    if (mbx0Wr) begin wr0Cnt++; wr0Data = mbx0WrData; mb0 = mbx0WrData; if (launchSeen) orderBad = 1; end
    if (mbx1Wr) begin wr1Cnt++; wr1Data = mbx1WrData; mb1 = mbx1WrData; if (launchSeen) orderBad = 1; end
    if (startNormal || startAlias) begin
      if (startNormal) normCnt++;
      if (startAlias) aliasCnt++;
      launchSeen = 1; running = 1; cnt = haltDelay;
    end else if (running) begin
      if (cnt == 1) begin
        halted = 1'b1; mb0 = fw0(mb0); mb1 = fw1(mb1); running = 0;
      end
      cnt--;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic runBoot(input logic [31:0] c, input logic d, input logic al,
                         input logic [1:0] en, input logic [31:0] i0, input logic [31:0] i1,
                         input int delay, input bit poke);
    int n;
    logic [2:0] ee;
    logic [31:0] e0, e1, h0, h1;
    logic [2:0] hErr;
    logic [1:0] hSub;
    string tag;
    @(negedge clk);
    cfgWord = c; needDual = d; aliasEn = al; mbxWrEn = en; mbx0In = i0; mbx1In = i1;
    haltDelay = delay; halted = 1'b0; running = 0;
    wr0Cnt = 0; wr1Cnt = 0; normCnt = 0; aliasCnt = 0; launchSeen = 0; orderBad = 0;
    ee = expErr(c, d);
    if (ee == 3'd0 && delay > T) ee = 3'd4;
    e0 = (ee == 3'd0) ? fw0(en[0] ? i0 : mb0) : 32'h0;
    e1 = (ee == 3'd0) ? fw1(en[1] ? i1 : mb1) : 32'h0;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    n = 1;
    while (done !== 1'b1 && n < T + 60) begin
      @(negedge clk);
      n++;
      if (poke && n == 6) startReq = 1'b1;
      if (poke && n == 7) startReq = 1'b0;
    end
    case (ee)
      3'd1: tag = "R2"; 3'd2: tag = "R3"; 3'd3: tag = "R5";
      3'd4: tag = "R9"; default: tag = "R8";
    endcase
    check(done === 1'b1, {tag, " done seen"}, 32'(done), 32'h1);
    check(errCode === ee, {tag, " errCode"}, 32'(errCode), 32'(ee));
    if (ee inside {3'd1, 3'd2, 3'd3}) begin
      check(n == 2, "R2 done latency on bad config", n, 2);
      check(wr0Cnt + wr1Cnt + normCnt + aliasCnt == 0, "R2 no side effects on bad config",
            wr0Cnt + wr1Cnt + normCnt + aliasCnt, 0);
    end else begin
      check(wr0Cnt == int'(en[0]), "R6 mailbox0 write count", wr0Cnt, en[0]);
      check(wr1Cnt == int'(en[1]), "R6 mailbox1 write count", wr1Cnt, en[1]);
      if (en[0]) check(wr0Data === i0, "R6 mailbox0 data", wr0Data, i0);
      if (en[1]) check(wr1Data === i1, "R6 mailbox1 data", wr1Data, i1);
      check(!orderBad, "R6 writes before launch", orderBad, 0);
      check((al ? aliasCnt : normCnt) == 1 && (al ? normCnt : aliasCnt) == 0,
            "R7 start path", {normCnt[15:0], aliasCnt[15:0]}, al ? 32'h1 : 32'h10000);
      if (ee == 3'd4) check(n == T + 4, "R9 timeout latency", n, T + 4);
    end
    check(res0 === e0, "R8 res0", res0, e0);
    check(res1 === e1, "R8 res1", res1, e1);
    check(subVer === c[5:4], "R4 subVer", subVer, c[5:4]);
    h0 = res0; h1 = res1; hErr = errCode; hSub = subVer;
    repeat (3) @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R10 idle after done", {done, busy}, 0);
    check(res0 === h0 && res1 === h1 && errCode === hErr && subVer === hSub,
          "R10 results held", res0, h0);
  endtask

  function automatic logic [31:0] mkCfg(input logic [3:0] rev, input logic [3:0] sub,
                                        input logic [2:0] sec, input logic rv);
    logic [31:0] c;
    c = $urandom;
    c[3:0] = rev; c[7:4] = sub; c[10:8] = sec; c[12] = rv;
    return c;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy === 0 && done === 0 && errCode === 0 && subVer === 0, "R1 reset flags",
          {busy, done, errCode, subVer}, 0);
    check(res0 === 0 && res1 === 0, "R1 reset results", res0 | res1, 0);
    check({mbx0Wr, mbx1Wr, startNormal, startAlias} === 4'b0, "R1 reset strobes",
          {mbx0Wr, mbx1Wr, startNormal, startAlias}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed corners
    runBoot(mkCfg(4'd0, 4'd1, 3'd0, 1'b1), 1'b0, 1'b0, 2'b11, 32'h11, 32'h22, 5, 0);  // R2 rev 0
    runBoot(mkCfg(4'd8, 4'd1, 3'd0, 1'b1), 1'b0, 1'b0, 2'b11, 32'h11, 32'h22, 5, 0);  // R2 rev 8
    runBoot(mkCfg(4'd9, 4'd1, 3'd1, 1'b1), 1'b0, 1'b0, 2'b11, 32'h11, 32'h22, 5, 0);  // R3 rev wins
    runBoot(mkCfg(4'd3, 4'd2, 3'd1, 1'b1), 1'b0, 1'b0, 2'b11, 32'h11, 32'h22, 5, 0);  // R3 sec 1
    runBoot(mkCfg(4'd3, 4'd2, 3'd4, 1'b1), 1'b0, 1'b0, 2'b11, 32'h11, 32'h22, 5, 0);  // R3 sec 4
    runBoot(mkCfg(4'd7, 4'd3, 3'd3, 1'b0), 1'b1, 1'b0, 2'b11, 32'h11, 32'h22, 5, 0);  // R5
    runBoot(mkCfg(4'd1, 4'd7, 3'd2, 1'b1), 1'b1, 1'b0, 2'b11, 32'hA1, 32'hB2, 3, 0);  // R8 normal
    runBoot(mkCfg(4'd7, 4'd4, 3'd0, 1'b0), 1'b0, 1'b1, 2'b01, 32'hC3, 32'hD4, 1, 0);  // R7 alias
    runBoot(mkCfg(4'd5, 4'd2, 3'd3, 1'b0), 1'b0, 1'b1, 2'b00, 32'hE5, 32'hF6, 7, 0);  // R6 no writes
    runBoot(mkCfg(4'd2, 4'd1, 3'd0, 1'b0), 1'b0, 1'b0, 2'b10, 32'h17, 32'h28, T, 0);  // R8 last cycle
    runBoot(mkCfg(4'd2, 4'd0, 3'd0, 1'b0), 1'b0, 1'b1, 2'b11, 32'h39, 32'h4A, T + 1, 0); // R9
    runBoot(mkCfg(4'd4, 4'd3, 3'd2, 1'b1), 1'b1, 1'b0, 2'b11, 32'h5B, 32'h6C, 20, 1); // R10 poke

    // constrained random
    for (int k = 0; k < 60; k++) begin
      logic [3:0] rv;
      logic [2:0] sc;
      int pick;
      rv = ($urandom % 8 == 0) ? 4'($urandom) : 4'(1 + $urandom % 7);
      pick = $urandom % 10;
      sc = (pick == 0) ? 3'($urandom) : (pick < 4 ? 3'd0 : (pick < 7 ? 3'd2 : 3'd3));
      runBoot(mkCfg(rv, 4'($urandom), sc, 1'($urandom)), 1'($urandom), 1'($urandom),
              2'($urandom), $urandom, $urandom,
              ($urandom % 6 == 0) ? T + 1 + $urandom % 4 : 1 + $urandom % T, 0);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule